// File: doc/BRIEF.md
# Retire-Stream Fingerprint Checker

This block turns the architectural updates retired on one core into a 32-bit running hash. Each retire cycle delivers up to four update records: a destination value, a register index, and, for memory operations, an effective address. Records are folded into the hash strictly in retirement order, lowest lane first. Once a programmable number of records has been absorbed, the block freezes the hash and offers it to the partner core. That core runs the same instruction stream in lockstep.

When the partner's fingerprint arrives, the two values are compared. Equal values produce a one-cycle commit pulse, which the checkpoint logic uses to save register state. Unequal values set a sticky error flag for the recovery logic. While the block waits for the partner, retirement is held back through the per-lane take mask. Because of this stall, the next chunk always starts from the seed and never mixes records from two chunks. In the full-size configuration the chunk length is 32768 records.

Top module: `retire_fingerprint_checker`

## Requirements
- R1: After reset, `fp_valid`, `commit` and `error` are 0, the record count is 0 and the hash holds the seed 0xFFFFFFFF.
- R2: Each record is folded in as a 70-bit word {data[31:0], addr[31:0], idx[4:0], is_mem}. The word is shifted in MSB first through a non-reflected CRC with polynomial 0x04C11DB7: for each bit, fb = crc[31] ^ bit, crc = crc << 1, and if fb is set, crc ^= poly. The addr field is the effective address when is_mem is 1 and zero otherwise.
- R3: Valid lanes are packed from lane 0. `ret_take` is a packed mask that never includes an invalid lane, and taken lanes are hashed in ascending lane order within the cycle.
- R4: The block takes no more lanes than the records still missing from the current chunk of `chunk_len` records. The remaining lanes are not taken. After the edge that absorbs the last record of a chunk, `fp_valid` is 1 and `fp_out` holds the chunk's hash.
- R5: While `fp_valid` is 1, `ret_take` is all zero and `fp_out` does not change.
- R6: The comparison happens in a cycle where both `fp_valid` and `peer_valid` are 1. On a match, `commit` is 1 for exactly the next cycle.
- R7: On a mismatch, `error` is 1 from the next cycle and `commit` stays 0.
- R8: `error` stays set until `err_clr` is asserted. If `err_clr` and a mismatch occur in the same cycle, the flag ends up set.
- R9: After a comparison, `fp_valid` drops, and the hash and count restart from the seed and zero for the next chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chunk_len | input | 16 | Records per chunk; at least 1 and held stable |
| ret_valid | input | 4 | Per-lane record valid, packed from lane 0 |
| ret_is_mem | input | 4 | Per-lane flag: record is a memory operation |
| ret_idx | input | 20 | Per-lane destination register index, 5 bits each |
| ret_data | input | 128 | Per-lane destination value, 32 bits each |
| ret_addr | input | 128 | Per-lane effective address, 32 bits each |
| ret_take | output | 4 | Per-lane accept; lanes not taken must be presented again |
| peer_fp | input | 32 | Partner core's fingerprint |
| peer_valid | input | 1 | Partner fingerprint is present |
| err_clr | input | 1 | Clears the error flag |
| fp_out | output | 32 | Local fingerprint (frozen while `fp_valid`) |
| fp_valid | output | 1 | Local fingerprint is offered to the partner |
| commit | output | 1 | One-cycle pulse on matching fingerprints |
| error | output | 1 | Sticky mismatch flag |

## Verification
Two events can fall in the same cycle: a mismatching comparison and an external error clear. The bench first clears the flag on its own during a wait. It then drives `err_clr` in the exact cycle that the partner presents a corrupted fingerprint. After that cycle the flag is expected to be set, since the new mismatch must win over the clear. A second overlap sits at the chunk edge, where the cycle that fills a chunk also offers more lanes than fit. That case is judged by the take mask stopping exactly at the boundary, and by the next chunk's hash starting from the seed.

// File: rtl/retfp_pkg.sv
package retfp_pkg;

  localparam int          FP_W    = 32;
  localparam logic [31:0] FP_POLY = 32'h04C1_1DB7;

  typedef enum logic {ST_GATHER, ST_SWAP} fp_state_e;

  // one message bit through the MSB-first CRC register
  function automatic logic [FP_W-1:0] fp_shift_bit(input logic [FP_W-1:0] c,
                                                   input logic            b);
    logic fb;
    fb = c[FP_W-1] ^ b;
    return {c[FP_W-2:0], 1'b0} ^ (fb ? FP_POLY : '0);
  endfunction

endpackage

// File: rtl/retfp_take.sv
module retfp_take #(
  parameter int LANES = 4,
  parameter int CNT_W = 16,
  parameter int NT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [LANES-1:0] valid,
  input  logic [CNT_W-1:0] room,
  output logic [LANES-1:0] take,
  output logic [NT_W-1:0]  n_take
);

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_lane
      assign take[gi] = active & valid[gi] & (room > CNT_W'(gi));
    end
  endgenerate

  always_comb begin
    n_take = '0;
    for (int i = 0; i < LANES; i++) n_take = n_take + NT_W'(take[i]);
  end

  logic [LANES-1:0] take_inc;
  assign take_inc = take + LANES'(1);

  assert_take_subset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take & ~valid) == '0);

  assert_take_packed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take & take_inc) == '0);

endmodule

// File: rtl/retfp_fold.sv
module retfp_fold
  import retfp_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic [FP_W-1:0]         crc_in,
  input  logic [LANES-1:0]        take,
  input  logic [LANES-1:0]        is_mem,
  input  logic [LANES*IDX_W-1:0]  idx,
  input  logic [LANES*DATA_W-1:0] data,
  input  logic [LANES*ADDR_W-1:0] addr,
  output logic [FP_W-1:0]         crc_out
);

  localparam int REC_W = DATA_W + ADDR_W + IDX_W + 1;

  logic [FP_W-1:0] stage [LANES+1];

  assign stage[0] = crc_in;

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_fold
      logic [REC_W-1:0] rec;
      logic [FP_W-1:0]  mixed;

      assign rec = {data[gi*DATA_W +: DATA_W],
                    (is_mem[gi] ? addr[gi*ADDR_W +: ADDR_W] : {ADDR_W{1'b0}}),
                    idx[gi*IDX_W +: IDX_W],
                    is_mem[gi]};

      always_comb begin
        mixed = stage[gi];
        for (int b = REC_W - 1; b >= 0; b--) mixed = fp_shift_bit(mixed, rec[b]);
      end

      assign stage[gi+1] = take[gi] ? mixed : stage[gi];
    end
  endgenerate

  assign crc_out = stage[LANES];

endmodule

// File: rtl/retfp_exchange.sv
module retfp_exchange
  import retfp_pkg::*;
#(
  parameter int          LANES = 4,
  parameter int          CNT_W = 16,
  parameter int          NT_W  = 3,
  parameter logic [31:0] SEED  = 32'hFFFF_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] chunk_len,
  input  logic [LANES-1:0] take,
  input  logic [NT_W-1:0]  n_take,
  input  logic [FP_W-1:0]  crc_fold,
  input  logic [FP_W-1:0]  peer_fp,
  input  logic             peer_valid,
  input  logic             err_clr,
  output logic             active,
  output logic [CNT_W-1:0] room,
  output logic [FP_W-1:0]  crc_q,
  output logic             fp_valid,
  output logic             commit,
  output logic             error
);

  fp_state_e        state_q, state_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic [FP_W-1:0]  crc_d;
  logic             commit_d, err_d;
  logic             acc_en;
  logic [CNT_W:0]   count_sum;
  logic             chunk_full, swap_now, same_fp;

  assign active    = (state_q == ST_GATHER);
  assign fp_valid  = (state_q == ST_SWAP);
  assign room      = (count_q < chunk_len) ? (chunk_len - count_q) : '0;
  assign count_sum = {1'b0, count_q} + (CNT_W+1)'(n_take);
  assign chunk_full = count_sum >= {1'b0, chunk_len};
  assign swap_now  = fp_valid && peer_valid;
  assign same_fp   = (crc_q == peer_fp);

  always_comb begin
    state_d  = state_q;
    count_d  = count_q;
    crc_d    = crc_q;
    acc_en   = 1'b0;
    commit_d = 1'b0;
    unique case (state_q)
      ST_GATHER: begin
        acc_en  = (|take) || chunk_full;
        crc_d   = crc_fold;
        count_d = count_sum[CNT_W-1:0];
        if (chunk_full) state_d = ST_SWAP;
      end
      ST_SWAP: begin
        if (peer_valid) begin
          acc_en   = 1'b1;
          crc_d    = SEED;
          count_d  = '0;
          state_d  = ST_GATHER;
          commit_d = same_fp;
        end
      end
      default: state_d = ST_GATHER;
    endcase
    err_d = (error & ~err_clr) | (swap_now & ~same_fp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_GATHER;
      count_q <= '0;
      crc_q   <= SEED;
      commit  <= 1'b0;
      error   <= 1'b0;
    end else begin
      state_q <= state_d;
      commit  <= commit_d;
      error   <= err_d;
      if (acc_en) begin
        count_q <= count_d;
        crc_q   <= crc_d;
      end
    end
  end

  assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fp_valid |-> (take == '0));

  assert_fp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_valid && $past(fp_valid)) |-> $stable(crc_q));

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fp_valid) |-> (crc_q == SEED && count_q == '0));

  assert_commit_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  assert_mismatch_nocommit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> !commit);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(error) && !$past(err_clr)) |-> error);

endmodule

// File: rtl/retire_fingerprint_checker.sv
module retire_fingerprint_checker
  import retfp_pkg::*;
#(
  parameter int          LANES     = 4,
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 32,
  parameter int          IDX_W     = 5,
  parameter int          CHUNK_MAX = 32768,
  parameter logic [31:0] SEED      = 32'hFFFF_FFFF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(CHUNK_MAX+1)-1:0] chunk_len,
  input  logic [LANES-1:0]          ret_valid,
  input  logic [LANES-1:0]          ret_is_mem,
  input  logic [LANES*IDX_W-1:0]    ret_idx,
  input  logic [LANES*DATA_W-1:0]   ret_data,
  input  logic [LANES*ADDR_W-1:0]   ret_addr,
  output logic [LANES-1:0]          ret_take,
  input  logic [FP_W-1:0]           peer_fp,
  input  logic                      peer_valid,
  input  logic                      err_clr,
  output logic [FP_W-1:0]           fp_out,
  output logic                      fp_valid,
  output logic                      commit,
  output logic                      error
);

  localparam int CNT_W = $clog2(CHUNK_MAX + 1);
  localparam int NT_W  = $clog2(LANES + 1);

  logic             active;
  logic [CNT_W-1:0] room;
  logic [NT_W-1:0]  n_take;
  logic [FP_W-1:0]  crc_q, crc_fold;

  retfp_take #(.LANES(LANES), .CNT_W(CNT_W), .NT_W(NT_W)) u_take (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .valid  (ret_valid),
    .room   (room),
    .take   (ret_take),
    .n_take (n_take)
  );

  retfp_fold #(.LANES(LANES), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fold (
    .crc_in  (crc_q),
    .take    (ret_take),
    .is_mem  (ret_is_mem),
    .idx     (ret_idx),
    .data    (ret_data),
    .addr    (ret_addr),
    .crc_out (crc_fold)
  );

  retfp_exchange #(.LANES(LANES), .CNT_W(CNT_W), .NT_W(NT_W), .SEED(SEED)) u_xchg (
    .clk        (clk),
    .rst_n      (rst_n),
    .chunk_len  (chunk_len),
    .take       (ret_take),
    .n_take     (n_take),
    .crc_fold   (crc_fold),
    .peer_fp    (peer_fp),
    .peer_valid (peer_valid),
    .err_clr    (err_clr),
    .active     (active),
    .room       (room),
    .crc_q      (crc_q),
    .fp_valid   (fp_valid),
    .commit     (commit),
    .error      (error)
  );

  assign fp_out = crc_q;

endmodule

// File: tb/tb_retire_fingerprint_checker.sv
module tb_retire_fingerprint_checker;

  localparam int CLK_P = 10;
  localparam int L     = 4;
  localparam int CH    = 6;
  localparam int NREC  = 30;
  localparam int NCHK  = 5;
  localparam logic [31:0] SEED = 32'hFFFF_FFFF;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [15:0]   chunk_len;
  logic [L-1:0]  ret_valid, ret_is_mem, ret_take;
  logic [L*5-1:0]  ret_idx;
  logic [L*32-1:0] ret_data, ret_addr;
  logic [31:0]   peer_fp, fp_out;
  logic          peer_valid, err_clr, fp_valid, commit, error;

  int checks = 0, failures = 0;
  bit drv_done = 0, peer_done = 0, finished = 0;
  bit mwait = 0;
  logic [31:0] exp_q [$];

  logic [31:0] r_data [NREC];
  logic [31:0] r_addr [NREC];
  logic [4:0]  r_idx  [NREC];
  logic        r_mem  [NREC];

  always #(CLK_P/2) clk = ~clk;

  retire_fingerprint_checker dut (
    .clk(clk), .rst_n(rst_n), .chunk_len(chunk_len),
    .ret_valid(ret_valid), .ret_is_mem(ret_is_mem), .ret_idx(ret_idx),
    .ret_data(ret_data), .ret_addr(ret_addr), .ret_take(ret_take),
    .peer_fp(peer_fp), .peer_valid(peer_valid), .err_clr(err_clr),
    .fp_out(fp_out), .fp_valid(fp_valid), .commit(commit), .error(error)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_fold(input logic [31:0] c, input int k);
    logic [69:0] w;
    logic fb;
    w = {r_data[k], (r_mem[k] ? r_addr[k] : 32'h0), r_idx[k], r_mem[k]};
    for (int b = 69; b >= 0; b--) begin
      fb = c[31] ^ w[b];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C1_1DB7;
    end
    return c;
  endfunction

  // driver: presents records, checks the take mask, pushes expected fingerprints
  initial begin
    logic [31:0] mcrc;
    int mcount, head, cyc;
    rst_n = 1'b0; chunk_len = 16'(CH);
    ret_valid = '0; ret_is_mem = '0; ret_idx = '0; ret_data = '0; ret_addr = '0;
    for (int k = 0; k < NREC; k++) begin
      r_data[k] = 32'h1357_9BDF * (k + 1) ^ 32'hA5A5_0000;
      r_addr[k] = 32'h8000_0040 + 32'(k * 8);
      r_idx[k]  = 5'(k * 7 + 3);
      r_mem[k]  = (k % 3 == 1);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fp_valid == 1'b0, "R1 fp_valid", 32'(fp_valid), 0);
    chk(commit == 1'b0, "R1 commit", 32'(commit), 0);
    chk(error == 1'b0, "R1 error", 32'(error), 0);
    mcrc = SEED; mcount = 0; head = 0; cyc = 0;
    while (head < NREC) begin
      int nv, n, expn;
      logic [L-1:0] expm;
      @(negedge clk);
      nv = (cyc * 3 + 1) % 5; cyc++;
      n  = (nv < NREC - head) ? nv : NREC - head;
      ret_valid = '0; ret_is_mem = '0;
      for (int i = 0; i < L; i++) begin
        if (i < n) begin
          ret_valid[i] = 1'b1;
          ret_is_mem[i] = r_mem[head+i];
          ret_idx[i*5 +: 5]   = r_idx[head+i];
          ret_data[i*32 +: 32] = r_data[head+i];
          ret_addr[i*32 +: 32] = r_addr[head+i];
        end
      end
      #2;
      expn = mwait ? 0 : ((n < CH - mcount) ? n : CH - mcount);
      expm = L'((1 << expn) - 1);
      if (mwait)
        chk(ret_take == expm, "R5 take while waiting", 32'(ret_take), 32'(expm));
      else if (expn < n)
        chk(ret_take == expm, "R4 take at boundary", 32'(ret_take), 32'(expm));
      else
        chk(ret_take == expm, "R3 take mask", 32'(ret_take), 32'(expm));
      for (int i = 0; i < expn; i++) mcrc = ref_fold(mcrc, head + i);
      mcount += expn; head += expn;
      if (mcount == CH) begin
        exp_q.push_back(mcrc);
        mcrc = SEED; mcount = 0; mwait = 1;
      end
    end
    @(negedge clk);
    ret_valid = '0;
    drv_done = 1;
  end

  // monitor and partner model: pops expected fingerprints and answers them
  initial begin
    bit corrupt [NCHK] = '{0, 1, 0, 1, 0};
    bit preclr  [NCHK] = '{0, 0, 0, 1, 0};
    bit sameclr [NCHK] = '{0, 0, 0, 1, 0};
    bit eerr;
    logic [31:0] expfp;
    peer_fp = '0; peer_valid = 1'b0; err_clr = 1'b0; eerr = 0;
    @(posedge rst_n);
    for (int k = 0; k < NCHK; k++) begin
      do @(negedge clk); while (!fp_valid);
      if (exp_q.size() == 0) begin
        chk(0, "R4 unexpected fingerprint", fp_out, 0);
        expfp = fp_out;
      end else begin
        expfp = exp_q.pop_front();
        chk(fp_out == expfp, (k == 0) ? "R2 fingerprint" : "R9 fingerprint after restart", fp_out, expfp);
      end
      @(negedge clk);
      chk(fp_valid && fp_out == expfp, "R5 fingerprint held", fp_out, expfp);
      if (preclr[k]) begin
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0; eerr = 0;
        chk(error == 1'b0, "R8 clear alone", 32'(error), 0);
      end
      peer_fp = corrupt[k] ? (expfp ^ 32'h0001_0000) : expfp;
      peer_valid = 1'b1;
      err_clr = sameclr[k];
      @(negedge clk);
      peer_valid = 1'b0; err_clr = 1'b0;
      eerr = (eerr & ~sameclr[k]) | corrupt[k];
      if (corrupt[k]) chk(commit == 1'b0, "R7 no commit on mismatch", 32'(commit), 0);
      else            chk(commit == 1'b1, "R6 commit on match", 32'(commit), 1);
      chk(error == eerr, sameclr[k] ? "R8 set wins over clear" : "R7 error flag", 32'(error), 32'(eerr));
      chk(fp_valid == 1'b0, "R9 fp_valid drops", 32'(fp_valid), 0);
      mwait = 0;
      @(negedge clk);
      chk(commit == 1'b0, "R6 single-cycle commit", 32'(commit), 0);
      chk(error == eerr, "R8 error sticky", 32'(error), 32'(eerr));
    end
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(error == 1'b0, "R8 final clear", 32'(error), 0);
    peer_done = 1;
  end

  initial begin
    wait (drv_done && peer_done);
    @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired R6 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule